// File: doc/BRIEF.md
# Multicycle 16-bit Load/Store Processor Core

This core executes a compact sixteen-bit instruction set one step at a time. It has eight general registers, a program counter, an instruction register, an address register and three condition flags: negative, zero and positive. Every instruction and every data item is one sixteen-bit word. The core reaches memory through a single synchronous port. The address and the write data are presented in one cycle, and the read data comes back in the next cycle.

Each instruction follows the same phases. It is fetched from the address in the program counter, and the program counter is incremented. The instruction is then decoded and its effective address is formed. Loads and stores go on to one or two memory phases; the indirect forms read a pointer word first. The core then writes a register or a memory word, or changes the program counter.

A debug port shows one selected register, the program counter and the flags. It also gives a one-cycle pulse after each instruction completes. The core never halts: a program that should stop ends in a branch to itself.

Top module: `cpu_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core clears all eight registers, loads PC with x3000, sets the flags to Z only (`dbg_flags` = 3'b010, ordered {N,Z,P}), and does not drive `mem_we`.
- R2: Each instruction word is read from the address in PC, and PC then holds that address plus one before the instruction executes.
- R3: ADD (opcode 0001) and AND (opcode 0101) write the register in bits 11:9 from the register in bits 8:6 and a second operand. When bit 5 is 0, the second operand is the register in bits 2:0. When bit 5 is 1, it is bits 4:0 sign-extended.
- R4: NOT (opcode 1001) writes the bitwise inverse of the register in bits 8:6 into the register in bits 11:9.
- R5: Every instruction that writes a register (ADD, AND, NOT, LD, LDI, LDR, LEA) sets exactly one flag: N when the written value is negative, Z when it is zero, and P otherwise. ST, STI, STR and BR leave the flags unchanged.
- R6: LD (opcode 0010) loads the word at PC plus the sign-extended bits 8:0. LDR (opcode 0110) loads the word at the register in bits 8:6 plus the sign-extended bits 5:0. Both write the register in bits 11:9.
- R7: LDI (opcode 1010) and STI (opcode 1011) first read a pointer word at PC plus the sign-extended bits 8:0. They then load from, or store to, the address held in that pointer.
- R8: ST (opcode 0011) stores to PC plus the sign-extended bits 8:0. STR (opcode 0111) stores to the register in bits 8:6 plus the sign-extended bits 5:0. Each store writes the register in bits 11:9 and raises `mem_we` for exactly one cycle. No other instruction raises `mem_we`.
- R9: LEA (opcode 1110) writes PC plus the sign-extended bits 8:0 into the register in bits 11:9 and does not write memory.
- R10: BR (opcode 0000) takes a mask in bits 11:9, ordered n, z, p. If any selected flag is set, PC becomes the incremented PC plus the sign-extended bits 8:0. Otherwise PC is the next word. A mask of 000 never branches.
- R11: JMP (opcode 1100) loads PC with the register in bits 8:6 and leaves the flags unchanged.
- R12: `dbg_reg` shows the register chosen by `dbg_sel`. `dbg_retire` is high for exactly one cycle after each instruction completes, and in that cycle the instruction's register, memory, flag and PC results are all visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 16 | Word address for memory |
| mem_wdata | output | 16 | Data to be written |
| mem_we | output | 1 | Write strobe for the address on `mem_addr` |
| mem_rdata | input | 16 | Read data, one cycle after the address |
| dbg_sel | input | 3 | Register index shown on `dbg_reg` |
| dbg_reg | output | 16 | Contents of the selected register |
| dbg_pc | output | 16 | Current program counter |
| dbg_flags | output | 3 | Condition flags {N,Z,P} |
| dbg_retire | output | 1 | One-cycle pulse after each instruction completes |

## Verification
The hardest cases to reach from the ports are branches and the indirect pointer chain. Each branch outcome depends on flags left behind by earlier instructions, and a taken or untaken path is only visible in the PC value that follows. The indirect forms need a pointer word placed in memory and an operand placed at the address that pointer names. The stimulus is one program that handles this. It places pointer words in memory that lead to separate data locations, so any confusion between the two reads shows up in the value loaded or stored. It also arranges the flag state before each BR so that masks 100, 010, 101 (twice, once failing and once matching) and 000 are each tried. Filler instructions sit in every skipped slot, so a wrongly taken path alters a register that is checked later.

// File: rtl/cpu_pkg.sv
// Package cpu_pkg
// Shared widths, opcode values, the phase encoding and small helper
// functions for the multicycle core. Assumes 16-bit words and 8 registers.
package cpu_pkg;

    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);

    localparam logic [3:0] OP_BR  = 4'b0000;
    localparam logic [3:0] OP_ADD = 4'b0001;
    localparam logic [3:0] OP_LD  = 4'b0010;
    localparam logic [3:0] OP_ST  = 4'b0011;
    localparam logic [3:0] OP_AND = 4'b0101;
    localparam logic [3:0] OP_LDR = 4'b0110;
    localparam logic [3:0] OP_STR = 4'b0111;
    localparam logic [3:0] OP_NOT = 4'b1001;
    localparam logic [3:0] OP_LDI = 4'b1010;
    localparam logic [3:0] OP_STI = 4'b1011;
    localparam logic [3:0] OP_JMP = 4'b1100;
    localparam logic [3:0] OP_LEA = 4'b1110;

    typedef enum logic [2:0] {
        PH_FETCH,   // present PC, bump PC
        PH_LATCH,   // capture the instruction word
        PH_EVAL,    // decode, form address, finish short instructions
        PH_PTR,     // present pointer address
        PH_PTRW,    // capture pointer into address register
        PH_DATA,    // present data address, store happens here
        PH_LOADW    // capture loaded data
    } phase_e;

    // Condition code derived from a written value, ordered {N,Z,P}
    function automatic logic [2:0] nzp_of(input logic [XLEN-1:0] v);
        return {v[XLEN-1], (v == '0), (!v[XLEN-1] && (v != '0))};
    endfunction

    function automatic logic is_store(input logic [3:0] op);
        return (op == OP_ST) || (op == OP_STR) || (op == OP_STI);
    endfunction

endpackage

// File: rtl/cpu_regfile.sv
// Module cpu_regfile
// General register file: one write port and three combinational read
// ports (two operands and one debug). All registers clear on reset.
// Assumes a synchronous active-low reset.
module cpu_regfile #(
    parameter int W  = 16,
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    input  logic [AW-1:0] ra_d,
    output logic [W-1:0]  rd_d
);

    logic [W-1:0] regs [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W-1:0] q;
        // One register: clear on reset, load when addressed
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && (wa == AW'(g)))
                q <= wd;
        end
        assign regs[g] = q;
    end

    assign rd_a = regs[ra_a];
    assign rd_b = regs[ra_b];
    assign rd_d = regs[ra_d];

endmodule

// File: rtl/cpu_alu.sv
// Module cpu_alu
// Operate unit for the three arithmetic/logic opcodes. Any other opcode
// yields zero; the caller only writes the result for operate opcodes.
module cpu_alu #(
    parameter int W = 16
) (
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    import cpu_pkg::*;

    // Select the operation by opcode
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_AND:  y = a & b;
            OP_NOT:  y = ~a;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/cpu_agen.sv
// Module cpu_agen
// Effective address unit: base register plus 6-bit offset for the
// base-relative forms, otherwise incremented PC plus 9-bit offset.
// Assumes pc already points past the current instruction.
module cpu_agen #(
    parameter int W = 16
) (
    input  logic [W-1:0] pc,
    input  logic [W-1:0] base,
    input  logic [8:0]   off,
    input  logic         use_base,
    output logic [W-1:0] ea
);
    logic [W-1:0] sx9;
    logic [W-1:0] sx6;

    // Sign-extend both offset widths and pick the sum
    always_comb begin
        sx9 = {{(W-9){off[8]}}, off};
        sx6 = {{(W-6){off[5]}}, off[5:0]};
        ea  = use_base ? (base + sx6) : (pc + sx9);
    end

endmodule

// File: rtl/cpu_core.sv
// Module cpu_core
// Multicycle 16-bit core. Steps each instruction through fetch, latch,
// evaluate and up to four memory phases. Talks to one synchronous memory
// whose read data arrives one cycle after the address. Never halts.
// Assumes synchronous active-low reset.
module cpu_core #(
    parameter logic [15:0] RESET_VEC = 16'h3000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] mem_addr,
    output logic [15:0] mem_wdata,
    output logic        mem_we,
    input  logic [15:0] mem_rdata,
    input  logic [2:0]  dbg_sel,
    output logic [15:0] dbg_reg,
    output logic [15:0] dbg_pc,
    output logic [2:0]  dbg_flags,
    output logic        dbg_retire
);
    import cpu_pkg::*;

    phase_e            phase_q;
    logic [XLEN-1:0]   pc_q, ir_q, mar_q;
    logic [2:0]        flags_q;
    logic              retire_q;

    logic [3:0]        opc;
    logic [RIDX-1:0]   dr, sr1, sr2;
    logic [XLEN-1:0]   ra_data, rb_data, alu_b, alu_y, ea;
    logic              rf_we, done;
    logic [XLEN-1:0]   rf_wd;

    assign opc = ir_q[15:12];
    assign dr  = ir_q[11:9];
    assign sr1 = ir_q[8:6];
    assign sr2 = ir_q[2:0];

    cpu_regfile #(.W(XLEN), .N(NREG)) i_rf (
        .clk(clk), .rst_n(rst_n),
        .we(rf_we), .wa(dr), .wd(rf_wd),
        .ra_a(sr1), .rd_a(ra_data),
        .ra_b(is_store(opc) ? dr : sr2), .rd_b(rb_data),
        .ra_d(dbg_sel), .rd_d(dbg_reg)
    );

    assign alu_b = ir_q[5] ? {{(XLEN-5){ir_q[4]}}, ir_q[4:0]} : rb_data;

    cpu_alu #(.W(XLEN)) i_alu (
        .op(opc), .a(ra_data), .b(alu_b), .y(alu_y)
    );

    cpu_agen #(.W(XLEN)) i_agen (
        .pc(pc_q), .base(ra_data), .off(ir_q[8:0]),
        .use_base((opc == OP_LDR) || (opc == OP_STR)), .ea(ea)
    );

    // Memory port, register write-back and completion decode
    always_comb begin
        mem_addr  = ((phase_q == PH_PTR) || (phase_q == PH_DATA)) ? mar_q : pc_q;
        mem_wdata = rb_data;
        mem_we    = (phase_q == PH_DATA) && is_store(opc);
        rf_we     = 1'b0;
        rf_wd     = alu_y;
        done      = 1'b0;
        case (phase_q)
            PH_EVAL: begin
                case (opc)
                    OP_ADD, OP_AND, OP_NOT: begin rf_we = 1'b1; done = 1'b1; end
                    OP_LEA: begin rf_we = 1'b1; rf_wd = ea; done = 1'b1; end
                    OP_LD, OP_LDR, OP_ST, OP_STR, OP_LDI, OP_STI: done = 1'b0;
                    default: done = 1'b1;
                endcase
            end
            PH_DATA:  done = is_store(opc);
            PH_LOADW: begin rf_we = 1'b1; rf_wd = mem_rdata; done = 1'b1; end
            default:  done = 1'b0;
        endcase
    end

    // Phase sequencer, PC, instruction and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
            pc_q    <= RESET_VEC;
            ir_q    <= '0;
            mar_q   <= '0;
        end else begin
            case (phase_q)
                PH_FETCH: begin
                    pc_q    <= pc_q + 1'b1;
                    phase_q <= PH_LATCH;
                end
                PH_LATCH: begin
                    ir_q    <= mem_rdata;
                    phase_q <= PH_EVAL;
                end
                PH_EVAL: begin
                    mar_q   <= ea;
                    phase_q <= PH_FETCH;
                    case (opc)
                        OP_LD, OP_LDR, OP_ST, OP_STR: phase_q <= PH_DATA;
                        OP_LDI, OP_STI:               phase_q <= PH_PTR;
                        OP_BR:  if (|(ir_q[11:9] & flags_q)) pc_q <= ea;
                        OP_JMP: pc_q <= ra_data;
                        default: ;
                    endcase
                end
                PH_PTR:   phase_q <= PH_PTRW;
                PH_PTRW: begin
                    mar_q   <= mem_rdata;
                    phase_q <= PH_DATA;
                end
                PH_DATA:  phase_q <= is_store(opc) ? PH_FETCH : PH_LOADW;
                default:  phase_q <= PH_FETCH;
            endcase
        end
    end

    // Condition flags follow every register write
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= 3'b010;
        else if (rf_we)
            flags_q <= nzp_of(rf_wd);
    end

    // Completion pulse, one cycle after the final phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            retire_q <= 1'b0;
        else
            retire_q <= done;
    end

    assign dbg_pc     = pc_q;
    assign dbg_flags  = flags_q;
    assign dbg_retire = retire_q;

endmodule

// File: rtl/cpu_core_chk.sv
// Module cpu_core_chk
// Property checker bound into cpu_core. Observes flags, PC, the store
// strobe and the completion pulse.
module cpu_core_chk #(
    parameter logic [15:0] RST_VEC = 16'h3000
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] pc,
    input logic [2:0]  flags,
    input logic [3:0]  opc,
    input logic        in_eval,
    input logic        mem_we,
    input logic        retire,
    input logic [15:0] base_val
);
    import cpu_pkg::*;

    AST_RESET_STATE:   assert property (@(posedge clk) !rst_n |=> (pc == RST_VEC) && (flags == 3'b010)); // R1
    AST_FLAGS_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n) $countones(flags) == 1); // R5
    AST_STORE_FLAGS:   assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> $stable(flags)); // R5
    AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> is_store(opc)); // R8
    AST_WE_ONE_CYCLE:  assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R8
    AST_JMP_TARGET:    assert property (@(posedge clk) disable iff (!rst_n) (in_eval && opc == OP_JMP) |=> pc == $past(base_val)); // R11
    AST_RETIRE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) retire |=> !retire); // R12

endmodule

bind cpu_core cpu_core_chk #(.RST_VEC(RESET_VEC)) i_chk (
    .clk(clk), .rst_n(rst_n), .pc(pc_q), .flags(flags_q), .opc(ir_q[15:12]),
    .in_eval(phase_q == cpu_pkg::PH_EVAL), .mem_we(mem_we),
    .retire(dbg_retire), .base_val(ra_data)
);

// File: tb/test_cpu_core.sv
`timescale 1ns/100ps
// Scoreboard bench: a driver task queues the expected outcome of each
// instruction, and a monitor pops one entry per completion pulse.
module test_cpu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_reg, dbg_pc;
    logic        mem_we, dbg_retire;
    logic [2:0]  dbg_sel = 3'd0;
    logic [2:0]  dbg_flags;

    logic [15:0] mem [0:4095];
    int checks = 0;
    int fails  = 0;
    int writes = 0;
    int cyc    = 0;

    typedef struct {
        string       rq;
        logic [15:0] pc;
        int          idx;    // 0..7 register, 8 memory word
        logic [15:0] addr;
        logic [15:0] val;
        logic [2:0]  fl;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    cpu_core i_cpu_core (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_rdata(mem_rdata), .dbg_sel(dbg_sel),
        .dbg_reg(dbg_reg), .dbg_pc(dbg_pc), .dbg_flags(dbg_flags),
        .dbg_retire(dbg_retire)
    );

    // Synchronous memory model, one-cycle read latency
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) begin
            mem[mem_addr[11:0]] <= mem_wdata;
            if (rst_n) writes <= writes + 1;
        end
        mem_rdata <= mem[mem_addr[11:0]];
    end

    task automatic chk(input string rq, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic push(input string rq, input logic [15:0] pc, input int idx,
                        input logic [15:0] addr, input logic [15:0] val,
                        input logic [2:0] fl);
        exp_t e;
        e.rq = rq; e.pc = pc; e.idx = idx; e.addr = addr; e.val = val; e.fl = fl;
        sb.push_back(e);
    endtask

    // Monitor: compare one expected entry per completion pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && dbg_retire && sb.size() != 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.idx < 8) dbg_sel = 3'(e.idx);
                #0.5;
                chk(e.rq, "pc", dbg_pc, e.pc);
                chk(e.rq, "flags", {13'd0, dbg_flags}, {13'd0, e.fl});
                if (e.idx < 8) chk(e.rq, "reg", dbg_reg, e.val);
                else           chk(e.rq, "mem", mem[e.addr[11:0]], e.val);
            end
        end
    end

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        // program at x3000
        mem[12'h000] = 16'hE2FF; // LEA R1 -> x3100
        mem[12'h001] = 16'h56E0; // AND R3,R3,#0
        mem[12'h002] = 16'h14FC; // ADD R2,R3,#-4
        mem[12'h003] = 16'h6841; // LDR R4,R1,#1
        mem[12'h004] = 16'h1B02; // ADD R5,R4,R2
        mem[12'h005] = 16'h9D7F; // NOT R6,R5
        mem[12'h006] = 16'h5F84; // AND R7,R6,R4
        mem[12'h007] = 16'h2010; // LD R0 <- x3018
        mem[12'h008] = 16'hA610; // LDI R3 via x3019
        mem[12'h009] = 16'h3A10; // ST R5 -> x301A
        mem[12'h00A] = 16'hBE10; // STI R7 via x301B
        mem[12'h00B] = 16'h787F; // STR R4,R1,#-1
        mem[12'h00C] = 16'h0803; // BRn +3 (not taken)
        mem[12'h00D] = 16'h0402; // BRz +2 (taken)
        mem[12'h00E] = 16'h1021; // filler
        mem[12'h00F] = 16'h1021; // filler
        mem[12'h010] = 16'h0A05; // BRnp +5 (not taken)
        mem[12'h011] = 16'h14AF; // ADD R2,R2,#15
        mem[12'h012] = 16'h0A01; // BRnp +1 (taken)
        mem[12'h013] = 16'h1021; // filler
        mem[12'h014] = 16'hEC0B; // LEA R6 -> x3020
        mem[12'h015] = 16'hC180; // JMP R6
        mem[12'h016] = 16'h1021; // filler
        mem[12'h017] = 16'h1021; // filler
        mem[12'h018] = 16'h8000; // data for LD
        mem[12'h019] = 16'h3102; // pointer for LDI
        mem[12'h01B] = 16'h3103; // pointer for STI
        mem[12'h020] = 16'h0000; // BR with empty mask
        mem[12'h021] = 16'h14FF; // ADD R2,R3,#-1
        mem[12'h022] = 16'h0FFF; // BRnzp -1, self loop
        mem[12'h101] = 16'h0007;
        mem[12'h102] = 16'h0000;

        push("R9",  16'h3001, 1, 0, 16'h3100, 3'b001);
        push("R3",  16'h3002, 3, 0, 16'h0000, 3'b010);
        push("R3",  16'h3003, 2, 0, 16'hFFFC, 3'b100);
        push("R6",  16'h3004, 4, 0, 16'h0007, 3'b001);
        push("R3",  16'h3005, 5, 0, 16'h0003, 3'b001);
        push("R4",  16'h3006, 6, 0, 16'hFFFC, 3'b100);
        push("R3",  16'h3007, 7, 0, 16'h0004, 3'b001);
        push("R6",  16'h3008, 0, 0, 16'h8000, 3'b100);
        push("R7",  16'h3009, 3, 0, 16'h0000, 3'b010);
        push("R8",  16'h300A, 8, 16'h301A, 16'h0003, 3'b010);
        push("R7",  16'h300B, 8, 16'h3103, 16'h0004, 3'b010);
        push("R8",  16'h300C, 8, 16'h30FF, 16'h0007, 3'b010);
        push("R10", 16'h300D, 3, 0, 16'h0000, 3'b010);
        push("R10", 16'h3010, 0, 0, 16'h8000, 3'b010);
        push("R10", 16'h3011, 0, 0, 16'h8000, 3'b010);
        push("R5",  16'h3012, 2, 0, 16'h000B, 3'b001);
        push("R10", 16'h3014, 0, 0, 16'h8000, 3'b001);
        push("R9",  16'h3015, 6, 0, 16'h3020, 3'b001);
        push("R11", 16'h3020, 6, 0, 16'h3020, 3'b001);
        push("R10", 16'h3021, 0, 0, 16'h8000, 3'b001);
        push("R2",  16'h3022, 2, 0, 16'hFFFF, 3'b100);
        push("R10", 16'h3022, 2, 0, 16'hFFFF, 3'b100);
        push("R12", 16'h3022, 1, 0, 16'h3100, 3'b100);

        // reset state, sampled while reset is still held
        repeat (3) @(posedge clk);
        @(negedge clk);
        dbg_sel = 3'd1;
        #0.5;
        chk("R1", "pc", dbg_pc, 16'h3000);
        chk("R1", "flags", {13'd0, dbg_flags}, 16'h0002);
        chk("R1", "reg1", dbg_reg, 16'h0000);
        chk("R1", "we", {15'd0, mem_we}, 16'h0000);
        chk("R12", "retire", {15'd0, dbg_retire}, 16'h0000);
        rst_n = 1'b1;

        while (sb.size() != 0 && cyc < 5000) @(negedge clk);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL watchdog: actual %0d pending expected 0", sb.size());
        end
        repeat (40) @(negedge clk);
        chk("R8", "write count", 16'(writes), 16'd3);
        chk("R2", "loop pc", dbg_pc >= 16'h3022 && dbg_pc <= 16'h3023 ? 16'h0001 : 16'h0000, 16'h0001);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule